// File: doc/BRIEF.md
# Energy Pulse Generator

This block converts a stream of signed active-power samples into pulse trains whose rate follows the power. Each sample arrives with a one-cycle strobe. The block multiplies the sample's magnitude by a programmable rate factor and adds the product to a fractional energy accumulator. Each time the accumulator passes a full quantum of 2^ACC_W, one pulse is owed.

Two lines serve energy registration, for example a mechanical counter or a stepper driver. One line carries active-low pulses. The other is a level that shows the sign of the latest power sample. A third line carries a unipolar calibration pulse stream. Its addend is scaled up by 2^CAL_SHIFT, so it runs at a higher rate. All pulses have a fixed low time and a guaranteed high gap between them. Any quanta that fall due while a pulse is in progress are queued and emitted later, so none are lost.

Top module: `energy_pulse_gen`

## Requirements
- R1: After reset, all three outputs are high. A high sign line means non-negative.
- R2: The total number of pulses on `pulse_no` equals floor(sum(|p|*rate) / 2^20), with ACC_W=20, summed over all strobed samples.
- R3: The total number of pulses on `cal_no` equals floor(sum(|p|*rate*16) / 2^20), with CAL_SHIFT=4. This gives at least as many pulses as `pulse_no`.
- R4: A negative sample contributes its magnitude. This includes the most negative code, -32768, which contributes 32768.
- R5: A sample with a rate of zero or a power of zero adds no energy and produces no pulse.
- R6: Every pulse on `pulse_no` and `cal_no` is low for exactly PULSE_LEN clocks (default 4).
- R7: Between two pulses on the same line, the line stays high for at least GAP_LEN clocks (default 2).
- R8: `neg_no` goes low when the latest strobed sample is negative. It goes high when that sample is zero or positive. The change takes effect once `pulse_no` is high.
- R9: `neg_no` does not change while a pulse on `pulse_no` is low, except on its first low cycle.
- R10: Quanta that arrive while a pulse is in progress are queued, up to 255 of them, and are all emitted later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe that marks a new power sample |
| power_i | input | 16 | Signed active power sample, two's complement |
| rate_i | input | 8 | Pulse-rate scale factor |
| pulse_no | output | 1 | Registration energy pulse, active low |
| neg_no | output | 1 | Sign level: low when the latest power is negative |
| cal_no | output | 1 | Calibration energy pulse, active low |

## Verification
Directed runs first check zero rate and zero power, which must leave both pulse lines idle. Next come matched positive and negative runs, whose equal pulse increments show that sign does not affect the count. A single sample at the most negative code queues more than a hundred calibration quanta and so exercises the backlog. A long random run then mixes signs, magnitudes and rates. In every case the cumulative pulse counts are compared with floor division of the summed energy. Line monitors measure each low time and each high gap. They also catch any sign change in the middle of a pulse.

// File: rtl/epg_pkg.sv
package epg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_GAP  = 2'd2
  } phase_e;
endpackage

// File: rtl/epg_scale.sv
module epg_scale #(
  parameter int PWR_W  = 16,
  parameter int RATE_W = 8,
  localparam int PROD_W = PWR_W + RATE_W
) (
  input  logic [PWR_W-1:0]  power_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [PROD_W-1:0] prod_o,
  output logic              neg_o
);
  logic [PWR_W-1:0] mag;

  // two's complement magnitude; most negative code maps to 2^(PWR_W-1)
  always_comb begin
    neg_o  = power_i[PWR_W-1];
    mag    = neg_o ? (~power_i + PWR_W'(1)) : power_i;
    prod_o = PROD_W'(mag) * PROD_W'(rate_i);
  end
endmodule

// File: rtl/epg_pulse_chan.sv
module epg_pulse_chan
  import epg_pkg::*;
#(
  parameter int ADD_W     = 28,
  parameter int ACC_W     = 20,
  parameter int PEND_W    = 8,
  parameter int PULSE_LEN = 4,
  parameter int GAP_LEN   = 2,
  localparam int SUM_W = ADD_W + 1,
  localparam int QW    = SUM_W - ACC_W,
  localparam int CW    = PEND_W + QW + 1,
  localparam int TW    = $clog2(PULSE_LEN + GAP_LEN + 1),
  localparam int RW    = $clog2(PULSE_LEN + GAP_LEN + 2) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [ADD_W-1:0] addend_i,
  output logic             out_no
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic [SUM_W-1:0]  sum;
  logic [QW-1:0]     quanta;
  logic [CW-1:0]     pend_sum;
  logic              start;
  phase_e            phase_q;
  logic [TW-1:0]     tmr_q;

  always_comb begin
    sum      = SUM_W'(acc_q) + SUM_W'(addend_i);
    quanta   = valid_i ? sum[SUM_W-1:ACC_W] : '0;
    acc_d    = valid_i ? sum[ACC_W-1:0] : acc_q;
    start    = (phase_q == PH_IDLE) && (pend_q != '0);
    pend_sum = CW'(pend_q) + CW'(quanta) - CW'(start);
    pend_d   = (pend_sum > CW'(PEND_MAX)) ? PEND_MAX : pend_sum[PEND_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      pend_q  <= '0;
      phase_q <= PH_IDLE;
      tmr_q   <= '0;
    end else begin
      acc_q  <= acc_d;
      pend_q <= pend_d;
      unique case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_LOW;
          tmr_q   <= TW'(PULSE_LEN - 1);
        end
        PH_LOW: if (tmr_q == '0) begin
          phase_q <= PH_GAP;
          tmr_q   <= TW'(GAP_LEN - 1);
        end else tmr_q <= tmr_q - TW'(1);
        PH_GAP: if (tmr_q == '0) phase_q <= PH_IDLE;
                else tmr_q <= tmr_q - TW'(1);
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign out_no = (phase_q != PH_LOW);

  // run-length observers for the line
  logic [RW-1:0] low_run_q, high_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run_q  <= '0;
      high_run_q <= RW'(GAP_LEN);
    end else if (!out_no) begin
      low_run_q  <= (low_run_q == '1) ? low_run_q : low_run_q + RW'(1);
      high_run_q <= '0;
    end else begin
      low_run_q  <= '0;
      high_run_q <= (high_run_q >= RW'(GAP_LEN)) ? high_run_q : high_run_q + RW'(1);
    end
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_no) |-> (low_run_q == RW'(PULSE_LEN))); // R6
  AST_MIN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_no) |-> (high_run_q >= RW'(GAP_LEN))); // R7
  AST_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && addend_i == '0 && pend_q == '0 && phase_q == PH_IDLE) |=> out_no); // R5
  AST_NO_BACKLOG_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !start) |=> $stable(pend_q)); // R10
endmodule

// File: rtl/energy_pulse_gen.sv
module energy_pulse_gen #(
  parameter int PWR_W     = 16,
  parameter int RATE_W    = 8,
  parameter int ACC_W     = 20,
  parameter int CAL_SHIFT = 4,
  parameter int PEND_W    = 8,
  parameter int PULSE_LEN = 4,
  parameter int GAP_LEN   = 2,
  localparam int PROD_W = PWR_W + RATE_W,
  localparam int ADD_W  = PROD_W + CAL_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [PWR_W-1:0]  power_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              pulse_no,
  output logic              neg_no,
  output logic              cal_no
);
  logic [PROD_W-1:0] prod;
  logic              neg_in;
  logic [1:0]        line_n;
  logic              sign_pend_q, sign_q;

  epg_scale #(.PWR_W(PWR_W), .RATE_W(RATE_W)) u_scale (
    .power_i(power_i), .rate_i(rate_i), .prod_o(prod), .neg_o(neg_in)
  );

  // channel 0: registration, channel 1: calibration (scaled up)
  for (genvar g = 0; g < 2; g++) begin : g_chan
    localparam int SH = (g == 0) ? 0 : CAL_SHIFT;
    logic [ADD_W-1:0] addend;
    assign addend = ADD_W'(prod) << SH;
    epg_pulse_chan #(
      .ADD_W(ADD_W), .ACC_W(ACC_W), .PEND_W(PEND_W),
      .PULSE_LEN(PULSE_LEN), .GAP_LEN(GAP_LEN)
    ) u_chan (
      .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
      .addend_i(addend), .out_no(line_n[g])
    );
  end

  // sign follows the latest sample but only moves while the pulse line is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sign_pend_q <= 1'b0;
      sign_q      <= 1'b0;
    end else begin
      if (valid_i) sign_pend_q <= neg_in;
      if (line_n[0]) sign_q <= sign_pend_q;
    end
  end

  assign pulse_no = line_n[0];
  assign cal_no   = line_n[1];
  assign neg_no   = ~sign_q;

  AST_SIGN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_no && $past(!pulse_no)) |-> $stable(neg_no)); // R9
  AST_SIGN_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pulse_no) |=> ##1 (!pulse_no || (neg_no == !$past(neg_in, 2)) || $past(valid_i))); // R8
endmodule

// File: tb/tb_energy_pulse_gen.sv
module tb_energy_pulse_gen;
  localparam int PULSE_LEN = 4;
  localparam int GAP_LEN   = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] power_i = '0;
  logic [7:0]  rate_i = '0;
  logic        pulse_no, neg_no, cal_no;

  energy_pulse_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .power_i(power_i),
    .rate_i(rate_i), .pulse_no(pulse_no), .neg_no(neg_no), .cal_no(cal_no)
  );

  always #10 clk_i = ~clk_i;

  int checks = 0, failures = 0;
  longint unsigned tot = 0;
  int n_reg = 0, n_cal = 0;
  int bad_width = 0, bad_gap = 0, bad_sign = 0;
  logic prev_p = 1'b1, prev_c = 1'b1, prev_s = 1'b1;
  int low_p = 0, low_c = 0, high_p = 100, high_c = 100;
  logic done = 1'b0;

  // line monitors, sampled away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (prev_p && !pulse_no) begin n_reg++; if (high_p < GAP_LEN) bad_gap++; end
      if (prev_c && !cal_no)   begin n_cal++; if (high_c < GAP_LEN) bad_gap++; end
      if (!prev_p && pulse_no && low_p != PULSE_LEN) bad_width++;
      if (!prev_c && cal_no && low_c != PULSE_LEN) bad_width++;
      if (!pulse_no && !prev_p && neg_no != prev_s) bad_sign++;
      if (pulse_no) begin high_p++; low_p = 0; end else begin low_p++; high_p = 0; end
      if (cal_no)   begin high_c++; low_c = 0; end else begin low_c++; high_c = 0; end
      prev_p = pulse_no; prev_c = cal_no; prev_s = neg_no;
    end
  end

  function automatic longint unsigned mag_of(logic [15:0] p);
    return p[15] ? longint'(17'h10000 - {1'b0, p}) : longint'(p);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] p, input logic [7:0] r, input int wait_cyc);
    @(negedge clk_i);
    power_i = p; rate_i = r; valid_i = 1'b1;
    tot += mag_of(p) * longint'(r);
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (wait_cyc) @(negedge clk_i);
  endtask

  task automatic check_counts(input string tag);
    repeat (300) @(negedge clk_i);
    chk(n_reg == int'(tot >> 20), {"R2 ", tag}, n_reg, tot >> 20);
    chk(n_cal == int'(tot >> 16), {"R3 ", tag}, n_cal, tot >> 16);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(pulse_no && cal_no && neg_no, "R1 reset lines high", {pulse_no, neg_no, cal_no}, 3'b111);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(pulse_no && cal_no && neg_no, "R1 after release", {pulse_no, neg_no, cal_no}, 3'b111);

    // R5: zero rate and zero power
    for (int i = 0; i < 10; i++) send(16'h8000, 8'd0, 20);
    for (int i = 0; i < 10; i++) send(16'd0, 8'd255, 20);
    repeat (50) @(negedge clk_i);
    chk(n_reg == 0 && n_cal == 0, "R5 no pulses", n_reg + n_cal, 0);

    // R2/R3 positive directed
    for (int i = 0; i < 20; i++) send(16'd1000, 8'd128, 62);
    check_counts("positive");
    chk(neg_no == 1'b1, "R8 positive sign", neg_no, 1);

    // R4 negative of same magnitude gives same increment
    begin
      int r0 = n_reg;
      for (int i = 0; i < 20; i++) send(-16'sd1000, 8'd128, 62);
      check_counts("negative");
      chk(n_reg - r0 >= 2, "R4 negative pulses", n_reg - r0, 2);
    end
    chk(neg_no == 1'b0, "R8 negative sign", neg_no, 0);

    // R8 zero counts as non-negative
    send(16'd0, 8'd10, 10);
    repeat (50) @(negedge clk_i);
    chk(neg_no == 1'b1, "R8 zero sign", neg_no, 1);

    // R4 / R10 most negative code, large backlog
    send(16'h8000, 8'd255, 10);
    repeat (1000) @(negedge clk_i);
    check_counts("R4 R10 backlog");

    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 200; i++) begin
      int m = int'($urandom_range(2000, 0));
      logic [15:0] p = ($urandom_range(1, 0) == 1) ? 16'(-m) : 16'(m);
      send(p, 8'($urandom_range(255, 0)), 62);
    end
    check_counts("random");
    chk(n_cal >= n_reg, "R3 cal not slower", n_cal, n_reg);

    send(-16'sd1500, 8'd200, 10);
    repeat (60) @(negedge clk_i);
    chk(neg_no == 1'b0, "R8 last random sign", neg_no, 0);

    chk(bad_width == 0, "R6 pulse width", bad_width, 0);
    chk(bad_gap == 0, "R7 gap", bad_gap, 0);
    chk(bad_sign == 0, "R9 sign held in pulse", bad_sign, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule